// File: doc/BRIEF.md
# Single-Descriptor Flash DMA Engine

This block moves flash data between the controller's data FIFOs and system memory under the control of one buffer descriptor that sits in memory. Software writes the descriptor's byte address into a configuration register. It then pulses `start` with the direction of the pending flash command. The engine fetches the four descriptor words over a narrow request/response memory port and checks the ownership flag. It then streams the buffer in 8-byte beats, and finally writes the status word back with ownership returned to software.

A transmit transfer reads beats from memory and pushes them into the transmit FIFO. A receive transfer pops beats from the receive FIFO and writes them to memory. Each outcome ends with a one-cycle event pulse: transmit-complete, receive-complete, or descriptor-unavailable. The memory port carries one request at a time. A request stays asserted, with its address and data steady, until the memory answers with `mem_ack`.

Top module: `flash_dma_engine`

## Requirements
- R1: The descriptor base register loads `cfg_wdata` only when `cfg_we` is high and `cfg_addr` equals 0x18. A write to any other offset leaves the base unchanged.
- R2: After `start`, the engine reads the descriptor as 32-bit words at base+0 (status), base+4 (sizes), base+8 (buffer pointer 0) and base+12 (buffer pointer 1), in that order. It never has more than one request outstanding, and it holds `mem_req`, `mem_addr` and `mem_we` until `mem_ack`.
- R3: If bit 31 of the status word is 0, the engine pulses `ev_desc_unavail`. It reads no other descriptor word, moves no data and writes nothing to memory.
- R4: The byte count is taken from bits 11:0 of the sizes word. The number of beats is the count rounded up to a multiple of 8, divided by 8. A count of zero moves no beats and still completes normally.
- R5: With `start_rx`=0 (transmit), beat k is read as an 8-byte word from pointer0+8k, where pointer 0 is 8-byte aligned. Each beat is pushed to the transmit FIFO in order, and only while `tx_full` is low.
- R6: With `start_rx`=1 (receive), the engine pops one beat when `rx_valid` is high. It writes beat k to pointer0+8k in order.
- R7: After the last beat, the engine writes the status word back to the base address as a 32-bit write. Bit 31 is cleared and every other bit is unchanged.
- R8: After the write-back is acknowledged, `ev_tx_done` (transmit) or `ev_rx_done` (receive) pulses for one cycle as `busy` falls. At most one event is high in any cycle.
- R9: Buffer pointer 1 is fetched but has no effect. No data beat touches memory outside the pointer-0 buffer.
- R10: Under reset, `busy`, `mem_req`, `tx_push`, `rx_pop` and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Begin a transfer (taken when idle) |
| start_rx | input | 1 | Direction: 1 flash-to-memory, 0 memory-to-flash |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_wide | output | 1 | 1 for an 8-byte beat, 0 for a 32-bit descriptor word |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data (descriptor word in bits 31:0) |
| mem_ack | input | 1 | Memory response for the current request |
| mem_rdata | input | 64 | Memory read data (descriptor word in bits 31:0) |
| tx_push | output | 1 | Push one beat into the transmit FIFO |
| tx_data | output | 64 | Transmit beat |
| tx_full | input | 1 | Transmit FIFO cannot take a beat |
| rx_valid | input | 1 | Receive FIFO holds a beat |
| rx_data | input | 64 | Receive beat |
| rx_pop | output | 1 | Take one beat from the receive FIFO |
| ev_tx_done | output | 1 | Transmit transfer finished |
| ev_rx_done | output | 1 | Receive transfer finished |
| ev_desc_unavail | output | 1 | Descriptor was not owned by the engine |

## Verification
The hardest case to reach is the 4095-byte transfer. It runs through 512 beats and has to finish with the exact beat count and a clean write-back. At the same time, memory latency, transmit back-pressure and receive-FIFO gaps all change from cycle to cycle. The bench reaches this case with directed maximum-size transfers in both directions, under the same random `mem_ack`, `tx_full` and `rx_valid` patterns used for the random runs. Unowned descriptors, zero-length buffers and writes to the wrong configuration offset are placed between random transfers. This shows that each one leaves no trace on the next transfer.

// File: rtl/flash_dma_engine.sv
module flash_dma_engine #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int SW       = 12,
  parameter int CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] BASE_OFS = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          start,
  input  logic          start_rx,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_push,
  output logic [DW-1:0] tx_data,
  input  logic          tx_full,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pop,
  output logic          ev_tx_done,
  output logic          ev_rx_done,
  output logic          ev_desc_unavail
);
  localparam int BB  = DW / 8;
  localparam int BSH = $clog2(BB);
  localparam int CW  = SW - BSH + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_SIZE, S_PTR0, S_PTR1, S_MRD, S_PUSH, S_POP, S_MWR, S_WB
  } state_t;

  state_t        state;
  logic [AW-1:0] base_q, ptr_q;
  logic [31:0]   stat_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] beat_q;
  logic          dir_q;
  logic [SW:0]   sz_round;

  wire ack  = mem_req && mem_ack;
  wire last = (left_q == CW'(1));

  assign sz_round = {1'b0, mem_rdata[SW-1:0]} + (SW+1)'(BB-1);

  assign busy     = (state != S_IDLE);
  assign mem_req  = state inside {S_STAT, S_SIZE, S_PTR0, S_PTR1, S_MRD, S_MWR, S_WB};
  assign mem_we   = state inside {S_MWR, S_WB};
  assign mem_wide = state inside {S_MRD, S_MWR};
  assign tx_push  = (state == S_PUSH) && !tx_full;
  assign tx_data  = beat_q;
  assign rx_pop   = (state == S_POP) && rx_valid;
  assign mem_wdata = (state == S_WB) ? {{(DW-32){1'b0}}, 1'b0, stat_q[30:0]} : beat_q;

  always_comb begin
    case (state)
      S_SIZE:  mem_addr = base_q + AW'(4);
      S_PTR0:  mem_addr = base_q + AW'(8);
      S_PTR1:  mem_addr = base_q + AW'(12);
      S_MRD,
      S_MWR:   mem_addr = ptr_q;
      default: mem_addr = base_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      base_q          <= '0;
      ptr_q           <= '0;
      stat_q          <= '0;
      left_q          <= '0;
      beat_q          <= '0;
      dir_q           <= 1'b0;
      ev_tx_done      <= 1'b0;
      ev_rx_done      <= 1'b0;
      ev_desc_unavail <= 1'b0;
    end else begin
      ev_tx_done      <= 1'b0;
      ev_rx_done      <= 1'b0;
      ev_desc_unavail <= 1'b0;
      if (cfg_we && cfg_addr == BASE_OFS) base_q <= cfg_wdata[AW-1:0];
      case (state)
        S_IDLE: if (start) begin
          dir_q <= start_rx;
          state <= S_STAT;
        end
        S_STAT: if (ack) begin
          stat_q <= mem_rdata[31:0];
          if (!mem_rdata[31]) begin
            ev_desc_unavail <= 1'b1;
            state <= S_IDLE;
          end else state <= S_SIZE;
        end
        S_SIZE: if (ack) begin
          left_q <= sz_round[SW:BSH];
          state  <= S_PTR0;
        end
        S_PTR0: if (ack) begin
          ptr_q <= mem_rdata[AW-1:0];
          state <= S_PTR1;
        end
        S_PTR1: if (ack) state <= (left_q == '0) ? S_WB : (dir_q ? S_POP : S_MRD);
        S_MRD: if (ack) begin
          beat_q <= mem_rdata;
          state  <= S_PUSH;
        end
        S_PUSH: if (!tx_full) begin
          ptr_q  <= ptr_q + AW'(BB);
          left_q <= left_q - CW'(1);
          state  <= last ? S_WB : S_MRD;
        end
        S_POP: if (rx_valid) begin
          beat_q <= rx_data;
          state  <= S_MWR;
        end
        S_MWR: if (ack) begin
          ptr_q  <= ptr_q + AW'(BB);
          left_q <= left_q - CW'(1);
          state  <= last ? S_WB : S_POP;
        end
        S_WB: if (ack) begin
          ev_tx_done <= !dir_q;
          ev_rx_done <= dir_q;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_tx_done, ev_rx_done, ev_desc_unavail})); // R8
  AST_EVENT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done || ev_rx_done || ev_desc_unavail) |-> !busy && $past(busy)); // R8
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_wide |-> !mem_wdata[31]); // R7
  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wide |-> mem_addr[BSH-1:0] == '0); // R5
endmodule

// File: tb/flash_dma_engine_test.sv
module flash_dma_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic start = 0, start_rx = 0;
  logic busy, mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr; logic [63:0] mem_wdata;
  logic mem_ack = 0; logic [63:0] mem_rdata = 0;
  logic tx_push; logic [63:0] tx_data; logic tx_full = 0;
  logic rx_valid = 0; logic [63:0] rx_data = 0; logic rx_pop;
  logic ev_tx_done, ev_rx_done, ev_desc_unavail;

  flash_dma_engine uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [0:1023];
  logic [63:0] got [0:511];
  logic [63:0] expd [0:511];
  int total = 0, bad = 0, cycles = 0;
  int push_cnt, rx_cnt, nrd, nwr, bad_acc, n_tx, n_rx, n_un, txn;
  logic [31:0] rd_addr [0:7];
  logic [31:0] cur_base, cur_ptr; int cur_beats;

  function automatic logic [63:0] pat(int t, int i);
    return {t[15:0], 16'hA5C3, i[15:0], ~i[15:0]};
  endfunction
  function automatic int beats_of(int size);
    return ((size & 32'hFFF) + 7) / 8;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, ex);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n && mem_req && mem_ack) begin
      if (mem_wide) begin
        if (mem_addr < cur_ptr || mem_addr >= cur_ptr + 32'(8*cur_beats)) bad_acc++;
        if (mem_we) mem[mem_addr[12:3]] = mem_wdata;
      end else if (mem_we) begin
        nwr++;
        if (mem_addr != cur_base) bad_acc++;
        if (mem_addr[2]) mem[mem_addr[12:3]][63:32] = mem_wdata[31:0];
        else             mem[mem_addr[12:3]][31:0]  = mem_wdata[31:0];
      end else begin
        if (nrd < 8) rd_addr[nrd] = mem_addr;
        nrd++;
      end
    end
    if (rst_n && tx_push) begin
      if (push_cnt < 512) got[push_cnt] = tx_data;
      push_cnt++;
    end
    if (rst_n && rx_pop) rx_cnt++;
  end

  always @(negedge clk) begin
    if (ev_tx_done) n_tx++;
    if (ev_rx_done) n_rx++;
    if (ev_desc_unavail) n_un++;
    if (mem_ack) mem_ack = 0;
    else if (mem_req && ($urandom % 3 == 0)) begin
      mem_ack = 1;
      if (mem_wide) mem_rdata = mem[mem_addr[12:3]];
      else mem_rdata = {32'h0, mem_addr[2] ? mem[mem_addr[12:3]][63:32] : mem[mem_addr[12:3]][31:0]};
    end
    tx_full  = ($urandom % 4 == 0);
    rx_valid = ($urandom % 3 != 0);
    rx_data  = pat(txn, rx_cnt);
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic put32(logic [31:0] a, logic [31:0] d);
    if (a[2]) mem[a[12:3]][63:32] = d; else mem[a[12:3]][31:0] = d;
  endtask
  function automatic logic [31:0] get32(logic [31:0] a);
    return a[2] ? mem[a[12:3]][63:32] : mem[a[12:3]][31:0];
  endfunction

  task automatic run(bit rx, logic [31:0] base, logic [31:0] stat, int size,
                     logic [31:0] ptr0, bit junk_cfg);
    bit owned = stat[31];
    int nb = owned ? beats_of(size) : 0;
    txn++;
    cur_base = base; cur_ptr = ptr0; cur_beats = nb;
    put32(base, stat); put32(base + 4, 32'(size) | 32'hABC0_0000 & 32'hFFFF_F000);
    put32(base + 8, ptr0); put32(base + 12, $urandom);
    for (int k = 0; k < beats_of(size); k++) begin
      expd[k] = {$urandom, $urandom};
      mem[ptr0[12:3] + 10'(k)] = expd[k];
    end
    cfg_write(8'h18, base);
    if (junk_cfg) cfg_write(8'h1C, base ^ 32'h0000_0100);
    push_cnt = 0; rx_cnt = 0; nrd = 0; nwr = 0; bad_acc = 0; n_tx = 0; n_rx = 0; n_un = 0;
    @(negedge clk); start = 1; start_rx = rx;
    @(negedge clk); start = 0;
    while (n_tx + n_rx + n_un == 0) @(negedge clk);
    @(negedge clk);
    if (junk_cfg) chk(rd_addr[0] == base, "R1", "base after write to other offset", rd_addr[0], base);
    if (owned) begin
      chk(nrd == 4 && rd_addr[1] == base + 4 && rd_addr[2] == base + 8 && rd_addr[3] == base + 12,
          "R2", "descriptor fetch order", rd_addr[3], base + 12);
      chk(rx ? rx_cnt == nb : push_cnt == nb, "R4", "beat count", rx ? rx_cnt : push_cnt, nb);
      if (!rx) begin
        int e = 0;
        for (int k = 0; k < nb && k < 512; k++) if (got[k] != expd[k]) e++;
        chk(e == 0, "R5", "transmit beat data mismatches", e, 0);
      end else begin
        int e = 0;
        for (int k = 0; k < nb; k++) if (mem[ptr0[12:3] + 10'(k)] != pat(txn, k)) e++;
        chk(e == 0, "R6", "receive beats in memory mismatches", e, 0);
      end
      chk(get32(base) == (stat & 32'h7FFF_FFFF) && nwr == 1, "R7", "status write-back",
          get32(base), stat & 32'h7FFF_FFFF);
      chk(n_tx == int'(!rx) && n_rx == int'(rx) && n_un == 0, "R8", "completion event",
          {n_tx, n_rx, n_un}, {int'(!rx), int'(rx), 0});
      chk(bad_acc == 0, "R9", "accesses outside buffer", bad_acc, 0);
    end else begin
      chk(n_un == 1 && n_tx == 0 && n_rx == 0 && nrd == 1, "R3", "unowned event and fetch",
          {n_un, nrd}, {1, 1});
      chk(push_cnt == 0 && rx_cnt == 0 && nwr == 0 && get32(base) == stat, "R3",
          "unowned moved data", push_cnt + rx_cnt + nwr, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) mem[i] = {$urandom, $urandom};
    txn = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !tx_push && !rx_pop && !ev_tx_done && !ev_rx_done && !ev_desc_unavail,
        "R10", "outputs under reset", {busy, mem_req, tx_push, rx_pop}, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 32'h40, 32'h8000_000C, 16, 32'h1000, 1);
    run(1, 32'h80, 32'h8000_000C, 0, 32'h1100, 0);
    run(0, 32'h90, 32'h8000_000C, 0, 32'h1100, 0);
    run(1, 32'h20, 32'h0000_000C, 64, 32'h1200, 0);
    run(0, 32'h30, 32'h0000_000C, 64, 32'h1200, 0);
    run(0, 32'h50, 32'h8123_450C, 1, 32'h1008, 0);
    run(1, 32'h60, 32'h8000_000C, 13, 32'h1010, 1);
    run(1, 32'h70, 32'h8000_000C, 4095, 32'h1000, 0);
    run(0, 32'hA0, 32'hFFFF_FFFF, 4095, 32'h1000, 0);
    for (int i = 0; i < 30; i++) begin
      logic [31:0] st = {($urandom % 6 != 0) ? 1'b1 : 1'b0, 27'($urandom), 4'hC};
      run(1'($urandom), 32'(($urandom % 32) * 16), st, $urandom % 600,
          32'h1000 + 32'(($urandom % 64) * 8), ($urandom % 5 == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule